// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This unit services the move-to and move-from instructions that reach a processor's special-purpose register space. The effective register number is the bitwise OR of a base register value and a 16-bit immediate. Its upper five bits pick a group and its lower eleven bits pick an index within that group. The unit holds the registers of this space: exception vector base, exception return PC, exception address, exception status, supervision, a 64-bit multiply-accumulate value, interrupt mask and pending status, and power management. It also holds a bank of shadow general-purpose registers and the way-0 match words of the translation buffers. Version, core index and core count are read-only constants.

Reads are combinational from address to data, so the pipeline can use the value in the cycle it asks for it. A read of a number that is not mapped returns the old destination value that the pipeline supplies. Writes take effect on the rising clock edge while the write strobe is high. Some registers have special write rules: the mask can only gain bits, the pending status clears the bits written as one, and the accumulator is written one half at a time. Some writes also cause one-cycle requests toward the rest of the core: a full translation flush, a single-page flush, a fetch redirect that also cancels the delay slot, and a halt.

Top module: `spr_access_unit`

## Requirements
- R1: The effective number is base OR zero-extended immediate. Bits 15:11 are the group and bits 10:0 are the index. A number with any bit above 15 set is unmapped.
- R2: A read of an unmapped number drives rd_data_o equal to old_rd_i. A write to an unmapped number changes no register and raises no request.
- R3: Group 5 index 1 is the low 32 bits of the accumulator and group 5 index 2 is the high 32 bits. A write replaces only the addressed half.
- R4: A write to the interrupt mask (group 9 index 0) ORs the data into the mask, so the mask can only gain bits.
- R5: The interrupt status (group 9 index 2) gains the bits of irq_set_i every cycle. A write to it clears the bits written as 1. When a bit is set and cleared in the same cycle, the set wins.
- R6: A write to the supervision register (group 0 index 17) raises tlb_flush_o for one cycle, in the cycle after the write, when bit 0 (supervisor), bit 5 (data translation) or bit 6 (instruction translation) changes. Changes to other bits raise nothing.
- R7: A write to power management (group 8 index 0) with bit 4 (doze) or bit 5 (sleep) set raises halt_o for one cycle. In that cycle resume_pc_o equals the cur_pc_i of the write cycle plus 4.
- R8: A read of group 0 index 16 returns cur_pc_i. A write there raises redirect_o for one cycle, with redirect_pc_o equal to the data, only when the data differs from cur_pc_i.
- R9: Shadow registers sit at group 0 index 1024 + 32*set + reg, for SHADOW_SETS sets. Any index past the last set is unmapped.
- R10: Way-0 match words sit at group 1 index 512 + entry, for TLB_SETS entries. A write with bit 0 clear raises page_flush_o for one cycle, with page_addr_o equal to the old word with its low PAGE_BITS bits cleared. Indices 768 to 1535 of group 1 are unmapped.
- R11: Group 0 index 0 reads VERSION and ignores writes. Index 128 reads CORE_ID and index 129 reads NUM_CORES.
- R12: After reset every register reads 0, except supervision, which reads 1. All requests are low.
- R13: Exception vector base (index 11), return PC (32), address (48) and status (64) in group 0 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_set_i | input | XLEN | Interrupt lines that set pending status bits |
| wr_en_i | input | 1 | Write strobe for a move-to access |
| base_i | input | XLEN | Base register value of the access |
| imm_i | input | 16 | Immediate of the access |
| wr_data_i | input | XLEN | Data to write |
| old_rd_i | input | XLEN | Old destination value, returned for unmapped reads |
| cur_pc_i | input | XLEN | PC of the accessing instruction |
| rd_data_o | output | XLEN | Read data |
| tlb_flush_o | output | 1 | Full translation flush request |
| page_flush_o | output | 1 | Single-page flush request |
| page_addr_o | output | XLEN | Page address for the page flush |
| redirect_o | output | 1 | Fetch redirect request that also cancels the delay slot |
| redirect_pc_o | output | XLEN | Redirect target |
| halt_o | output | 1 | Halt request |
| resume_pc_o | output | XLEN | PC to resume from after the halt |

## Verification
The interrupt status register is the one place where two functions fall on the same bit in the same cycle. The interrupt lines set a pending bit while a software write clears that same bit. The bench drives irq_set_i and a clearing write of the same bit in one cycle, then reads the register back. The bit must survive the clear. A second clearing write, made with the lines quiet, must then remove it.

// File: rtl/spr_pkg.sv
`timescale 1ns/1ps
package spr_pkg;
    localparam int IDX_W = 11;
    localparam int GRP_W = 5;

    localparam int SR_SUP_BIT   = 0;
    localparam int SR_DXLAT_BIT = 5;
    localparam int SR_IXLAT_BIT = 6;
    localparam int PM_DOZE_BIT  = 4;
    localparam int PM_SLEEP_BIT = 5;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_VER, SEL_VECBASE, SEL_NEXTPC, SEL_SUPV, SEL_EXCPC,
        SEL_EXCADDR, SEL_EXCSTAT, SEL_COREIDX, SEL_CORECNT, SEL_SHADOW,
        SEL_MATCH, SEL_ACC_LO, SEL_ACC_HI, SEL_PWR, SEL_IRQMASK, SEL_IRQSTAT
    } spr_sel_e;

    typedef struct packed {
        spr_sel_e         sel;
        logic [IDX_W-1:0] off;
    } spr_dec_t;
endpackage

// File: rtl/spr_addr_decode.sv
`timescale 1ns/1ps
module spr_addr_decode
    import spr_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int SHADOW_SETS = 2,
    parameter int TLB_SETS    = 8
) (
    input  logic [XLEN-1:0] addr_i,
    output spr_dec_t        dec_o
);
    localparam int SH_BASE = 1024;
    localparam int SH_END  = SH_BASE + SHADOW_SETS * 32;
    localparam int MT_BASE = 512;
    localparam int MT_END  = MT_BASE + TLB_SETS;

    logic [GRP_W-1:0] grp;
    int               ix;

    always_comb begin
        grp       = addr_i[15:11];
        ix        = int'(addr_i[10:0]);
        dec_o.sel = SEL_NONE;
        dec_o.off = '0;
        if (addr_i[XLEN-1:16] == '0) begin
            case (grp)
                5'd0: begin
                    case (ix)
                        0:       dec_o.sel = SEL_VER;
                        11:      dec_o.sel = SEL_VECBASE;
                        16:      dec_o.sel = SEL_NEXTPC;
                        17:      dec_o.sel = SEL_SUPV;
                        32:      dec_o.sel = SEL_EXCPC;
                        48:      dec_o.sel = SEL_EXCADDR;
                        64:      dec_o.sel = SEL_EXCSTAT;
                        128:     dec_o.sel = SEL_COREIDX;
                        129:     dec_o.sel = SEL_CORECNT;
                        default: begin
                            if (ix >= SH_BASE && ix < SH_END) begin
                                dec_o.sel = SEL_SHADOW;
                                dec_o.off = IDX_W'(ix - SH_BASE);
                            end
                        end
                    endcase
                end
                5'd1: begin
                    if (ix >= MT_BASE && ix < MT_END) begin
                        dec_o.sel = SEL_MATCH;
                        dec_o.off = IDX_W'(ix - MT_BASE);
                    end
                end
                5'd5: begin
                    if (ix == 1) dec_o.sel = SEL_ACC_LO;
                    else if (ix == 2) dec_o.sel = SEL_ACC_HI;
                end
                5'd8: begin
                    if (ix == 0) dec_o.sel = SEL_PWR;
                end
                5'd9: begin
                    if (ix == 0) dec_o.sel = SEL_IRQMASK;
                    else if (ix == 2) dec_o.sel = SEL_IRQSTAT;
                end
                default: dec_o.sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/spr_reg_array.sv
`timescale 1ns/1ps
module spr_reg_array
    import spr_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] addr_i,
    input  logic [XLEN-1:0]  wdata_i,
    output logic [XLEN-1:0]  rdata_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [XLEN-1:0] mem_d [DEPTH];
    logic [XLEN-1:0] mem_q [DEPTH];
    logic [AW-1:0]   slot;
    logic            unused_hi;

    assign slot      = addr_i[AW-1:0];
    assign unused_hi = |addr_i[IDX_W-1:AW];
    assign rdata_o   = mem_q[slot];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[slot] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/spr_access_unit.sv
`timescale 1ns/1ps
module spr_access_unit
    import spr_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          SHADOW_SETS = 2,
    parameter int          TLB_SETS    = 8,
    parameter int          PAGE_BITS   = 13,
    parameter int unsigned VERSION     = 32'h1200_0001,
    parameter int unsigned CORE_ID     = 0,
    parameter int unsigned NUM_CORES   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] irq_set_i,
    input  logic            wr_en_i,
    input  logic [XLEN-1:0] base_i,
    input  logic [15:0]     imm_i,
    input  logic [XLEN-1:0] wr_data_i,
    input  logic [XLEN-1:0] old_rd_i,
    input  logic [XLEN-1:0] cur_pc_i,
    output logic [XLEN-1:0] rd_data_o,
    output logic            tlb_flush_o,
    output logic            page_flush_o,
    output logic [XLEN-1:0] page_addr_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            halt_o,
    output logic [XLEN-1:0] resume_pc_o
);
    localparam int              ACC_W     = 2 * XLEN;
    localparam int              SH_DEPTH  = SHADOW_SETS * 32;
    localparam logic [XLEN-1:0] SUPV_RST  = XLEN'(1) << SR_SUP_BIT;
    localparam logic [XLEN-1:0] SUPV_MODE = (XLEN'(1) << SR_SUP_BIT)
                                          | (XLEN'(1) << SR_DXLAT_BIT)
                                          | (XLEN'(1) << SR_IXLAT_BIT);
    localparam logic [XLEN-1:0] PAGE_LOW  = (XLEN'(1) << PAGE_BITS) - XLEN'(1);

    typedef struct packed {
        logic [XLEN-1:0]  vecbase;
        logic [XLEN-1:0]  supv;
        logic [XLEN-1:0]  excpc;
        logic [XLEN-1:0]  excaddr;
        logic [XLEN-1:0]  excstat;
        logic [XLEN-1:0]  pwr;
        logic [XLEN-1:0]  irqmask;
        logic [XLEN-1:0]  irqstat;
        logic [ACC_W-1:0] acc;
        logic             flush;
        logic             pflush;
        logic [XLEN-1:0]  paddr;
        logic             redir;
        logic [XLEN-1:0]  rpc;
        logic             halt;
        logic [XLEN-1:0]  respc;
    } spr_state_t;

    spr_state_t      st_d, st_q;
    spr_dec_t        dec;
    logic [XLEN-1:0] eff_addr;
    logic [XLEN-1:0] sh_rdata, mt_rdata;
    logic            sh_we, mt_we;
    logic [XLEN-1:0] stat_clr;

    assign eff_addr = base_i | {{(XLEN-16){1'b0}}, imm_i};

    spr_addr_decode #(
        .XLEN(XLEN), .SHADOW_SETS(SHADOW_SETS), .TLB_SETS(TLB_SETS)
    ) u_dec (
        .addr_i(eff_addr),
        .dec_o (dec)
    );

    assign sh_we = wr_en_i && (dec.sel == SEL_SHADOW);
    assign mt_we = wr_en_i && (dec.sel == SEL_MATCH);

    spr_reg_array #(.XLEN(XLEN), .DEPTH(SH_DEPTH)) u_shadow (
        .clk(clk), .rst_n(rst_n), .we_i(sh_we), .addr_i(dec.off),
        .wdata_i(wr_data_i), .rdata_o(sh_rdata)
    );

    spr_reg_array #(.XLEN(XLEN), .DEPTH(TLB_SETS)) u_match (
        .clk(clk), .rst_n(rst_n), .we_i(mt_we), .addr_i(dec.off),
        .wdata_i(wr_data_i), .rdata_o(mt_rdata)
    );

    // Next-state computation: write rules and one-cycle requests.
    always_comb begin
        st_d        = st_q;
        st_d.flush  = 1'b0;
        st_d.pflush = 1'b0;
        st_d.redir  = 1'b0;
        st_d.halt   = 1'b0;

        stat_clr     = (wr_en_i && dec.sel == SEL_IRQSTAT) ? wr_data_i : '0;
        st_d.irqstat = (st_q.irqstat & ~stat_clr) | irq_set_i;

        if (wr_en_i) begin
            case (dec.sel)
                SEL_VECBASE: st_d.vecbase = wr_data_i;
                SEL_EXCPC:   st_d.excpc   = wr_data_i;
                SEL_EXCADDR: st_d.excaddr = wr_data_i;
                SEL_EXCSTAT: st_d.excstat = wr_data_i;
                SEL_SUPV: begin
                    st_d.supv  = wr_data_i;
                    st_d.flush = |((st_q.supv ^ wr_data_i) & SUPV_MODE);
                end
                SEL_NEXTPC: begin
                    if (wr_data_i != cur_pc_i) begin
                        st_d.redir = 1'b1;
                        st_d.rpc   = wr_data_i;
                    end
                end
                SEL_PWR: begin
                    st_d.pwr = wr_data_i;
                    if (wr_data_i[PM_DOZE_BIT] || wr_data_i[PM_SLEEP_BIT]) begin
                        st_d.halt  = 1'b1;
                        st_d.respc = cur_pc_i + XLEN'(4);
                    end
                end
                SEL_MATCH: begin
                    if (!wr_data_i[0]) begin
                        st_d.pflush = 1'b1;
                        st_d.paddr  = mt_rdata & ~PAGE_LOW;
                    end
                end
                SEL_ACC_LO:  st_d.acc[XLEN-1:0]     = wr_data_i;
                SEL_ACC_HI:  st_d.acc[ACC_W-1:XLEN] = wr_data_i;
                SEL_IRQMASK: st_d.irqmask = st_q.irqmask | wr_data_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.supv <= SUPV_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // Combinational read path.
    always_comb begin
        case (dec.sel)
            SEL_VER:     rd_data_o = XLEN'(VERSION);
            SEL_VECBASE: rd_data_o = st_q.vecbase;
            SEL_NEXTPC:  rd_data_o = cur_pc_i;
            SEL_SUPV:    rd_data_o = st_q.supv;
            SEL_EXCPC:   rd_data_o = st_q.excpc;
            SEL_EXCADDR: rd_data_o = st_q.excaddr;
            SEL_EXCSTAT: rd_data_o = st_q.excstat;
            SEL_COREIDX: rd_data_o = XLEN'(CORE_ID);
            SEL_CORECNT: rd_data_o = XLEN'(NUM_CORES);
            SEL_SHADOW:  rd_data_o = sh_rdata;
            SEL_MATCH:   rd_data_o = mt_rdata;
            SEL_ACC_LO:  rd_data_o = st_q.acc[XLEN-1:0];
            SEL_ACC_HI:  rd_data_o = st_q.acc[ACC_W-1:XLEN];
            SEL_PWR:     rd_data_o = st_q.pwr;
            SEL_IRQMASK: rd_data_o = st_q.irqmask;
            SEL_IRQSTAT: rd_data_o = st_q.irqstat;
            default:     rd_data_o = old_rd_i;
        endcase
    end

    assign tlb_flush_o   = st_q.flush;
    assign page_flush_o  = st_q.pflush;
    assign page_addr_o   = st_q.paddr;
    assign redirect_o    = st_q.redir;
    assign redirect_pc_o = st_q.rpc;
    assign halt_o        = st_q.halt;
    assign resume_pc_o   = st_q.respc;
endmodule

// File: rtl/spr_access_checker.sv
`timescale 1ns/1ps
module spr_access_checker #(
    parameter int XLEN      = 32,
    parameter int PAGE_BITS = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en_i,
    input logic [XLEN-1:0] base_i,
    input logic [15:0]     imm_i,
    input logic [XLEN-1:0] wr_data_i,
    input logic [XLEN-1:0] cur_pc_i,
    input logic            tlb_flush_o,
    input logic            page_flush_o,
    input logic [XLEN-1:0] page_addr_o,
    input logic            redirect_o,
    input logic [XLEN-1:0] redirect_pc_o,
    input logic            halt_o,
    input logic [XLEN-1:0] resume_pc_o
);
    localparam logic [XLEN-1:0] LOW_MASK = (XLEN'(1) << PAGE_BITS) - XLEN'(1);
    localparam logic [XLEN-1:0] SUPV_NUM = XLEN'(17);

    logic [XLEN-1:0] eff;
    assign eff = base_i | {{(XLEN-16){1'b0}}, imm_i};

    assert_flush_from_supv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_o |-> ($past(wr_en_i) && $past(eff) == SUPV_NUM));

    assert_halt_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> ($past(wr_en_i) && resume_pc_o == $past(cur_pc_i) + XLEN'(4)
                    && ($past(wr_data_i[4]) || $past(wr_data_i[5]))));

    assert_redirect_differs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> ($past(wr_en_i) && redirect_pc_o == $past(wr_data_i)
                        && redirect_pc_o != $past(cur_pc_i)));

    assert_page_flush_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        page_flush_o |-> ($past(wr_en_i) && !$past(wr_data_i[0])
                          && (page_addr_o & LOW_MASK) == '0));

    // One access per cycle can raise at most one request (R2).
    assert_single_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tlb_flush_o, page_flush_o, redirect_o, halt_o}));
endmodule

bind spr_access_unit spr_access_checker #(.XLEN(XLEN), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .base_i(base_i), .imm_i(imm_i),
    .wr_data_i(wr_data_i), .cur_pc_i(cur_pc_i), .tlb_flush_o(tlb_flush_o),
    .page_flush_o(page_flush_o), .page_addr_o(page_addr_o), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .halt_o(halt_o), .resume_pc_o(resume_pc_o)
);

// File: tb/tb_spr_access_unit.sv
`timescale 1ns/1ps
module tb_spr_access_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_set_i, base_i, wr_data_i, old_rd_i, cur_pc_i;
    logic [15:0] imm_i;
    logic        wr_en_i;
    logic [31:0] rd_data_o, page_addr_o, redirect_pc_o, resume_pc_o;
    logic        tlb_flush_o, page_flush_o, redirect_o, halt_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    spr_access_unit #(.CORE_ID(3), .NUM_CORES(4)) dut (
        .clk(clk), .rst_n(rst_n), .irq_set_i(irq_set_i), .wr_en_i(wr_en_i),
        .base_i(base_i), .imm_i(imm_i), .wr_data_i(wr_data_i), .old_rd_i(old_rd_i),
        .cur_pc_i(cur_pc_i), .rd_data_o(rd_data_o), .tlb_flush_o(tlb_flush_o),
        .page_flush_o(page_flush_o), .page_addr_o(page_addr_o), .redirect_o(redirect_o),
        .redirect_pc_o(redirect_pc_o), .halt_o(halt_o), .resume_pc_o(resume_pc_o)
    );

    typedef struct {
        int          src;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    event  sample_ev;

    function automatic logic [31:0] observe(int src);
        case (src)
            0: return rd_data_o;
            1: return {31'd0, tlb_flush_o};
            2: return {31'd0, page_flush_o};
            3: return page_addr_o;
            4: return {31'd0, redirect_o};
            5: return redirect_pc_o;
            6: return {31'd0, halt_o};
            default: return resume_pc_o;
        endcase
    endfunction

    // Monitor: pops expectations and compares against the outputs.
    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = observe(it.src);
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s out%0d actual %h expected %h", it.req, it.src, act, it.exp);
                end
            end
        end
    end

    function automatic logic [15:0] num(int g, int i);
        return {5'(g), 11'(i)};
    endfunction

    task automatic push(int src, logic [31:0] e, string r);
        item_t it;
        it.src = src; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    task automatic judge();
        #0.4;
        -> sample_ev;
        #0.4;
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        base_i = '0; imm_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic [31:0] old, logic [31:0] e, string r);
        base_i = '0; imm_i = a; old_rd_i = old;
        push(0, e, r);
        judge();
    endtask

    task automatic reqs(bit f, bit p, bit rdr, bit h, string r);
        push(1, {31'd0, f}, r);
        push(2, {31'd0, p}, r);
        push(4, {31'd0, rdr}, r);
        push(6, {31'd0, h}, r);
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; irq_set_i = 0; base_i = 0; imm_i = 0; wr_data_i = 0;
        old_rd_i = 0; cur_pc_i = 32'h1000; wr_en_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R12: reset state
        reqs(0, 0, 0, 0, "R12"); judge();
        rd(num(0, 11), 32'hDEAD_0001, 32'h0, "R12");
        rd(num(0, 17), 32'hDEAD_0002, 32'h1, "R12");
        rd(num(9, 0),  32'hDEAD_0003, 32'h0, "R12");
        rd(num(5, 2),  32'hDEAD_0004, 32'h0, "R12");

        // R1: number formed by OR of base and immediate
        @(negedge clk);
        base_i = 32'h0000_0008; imm_i = 16'h0003; wr_data_i = 32'h1234_0000; wr_en_i = 1;
        @(negedge clk);
        wr_en_i = 0;
        rd(num(0, 11), 32'h0, 32'h1234_0000, "R1");
        base_i = 32'h0001_0000; imm_i = num(0, 11); old_rd_i = 32'h5A5A_5A5A;
        push(0, 32'h5A5A_5A5A, "R1"); judge();

        // R13: plain registers
        wr(num(0, 32), 32'hA000_0010);
        wr(num(0, 48), 32'hB000_0020);
        wr(num(0, 64), 32'hC000_0030);
        rd(num(0, 32), 0, 32'hA000_0010, "R13");
        rd(num(0, 48), 0, 32'hB000_0020, "R13");
        rd(num(0, 64), 0, 32'hC000_0030, "R13");

        // R2: unmapped read and write
        rd(num(3, 0), 32'hCAFE_F00D, 32'hCAFE_F00D, "R2");
        wr(num(0, 12), 32'hFFFF_FFFF);
        reqs(0, 0, 0, 0, "R2"); judge();
        rd(num(0, 11), 0, 32'h1234_0000, "R2");

        // R3: accumulator halves
        wr(num(5, 1), 32'h1111_1111);
        wr(num(5, 2), 32'h2222_2222);
        rd(num(5, 1), 0, 32'h1111_1111, "R3");
        rd(num(5, 2), 0, 32'h2222_2222, "R3");
        wr(num(5, 1), 32'h0000_0033);
        rd(num(5, 2), 0, 32'h2222_2222, "R3");
        rd(num(5, 1), 0, 32'h0000_0033, "R3");

        // R4: mask only gains bits
        wr(num(9, 0), 32'h0F);
        wr(num(9, 0), 32'hF0);
        rd(num(9, 0), 0, 32'hFF, "R4");
        wr(num(9, 0), 32'h0);
        rd(num(9, 0), 0, 32'hFF, "R4");

        // R5: pending status set, clear, and collision
        @(negedge clk); irq_set_i = 32'h5;
        @(negedge clk); irq_set_i = 32'h0;
        rd(num(9, 2), 0, 32'h5, "R5");
        wr(num(9, 2), 32'h1);
        rd(num(9, 2), 0, 32'h4, "R5");
        @(negedge clk);
        base_i = 0; imm_i = num(9, 2); wr_data_i = 32'h4; wr_en_i = 1; irq_set_i = 32'h4;
        @(negedge clk);
        wr_en_i = 0; irq_set_i = 0;
        rd(num(9, 2), 0, 32'h4, "R5");
        wr(num(9, 2), 32'h4);
        rd(num(9, 2), 0, 32'h0, "R5");

        // R6: supervision changes
        wr(num(0, 17), 32'h05);
        reqs(0, 0, 0, 0, "R6"); judge();
        rd(num(0, 17), 0, 32'h05, "R6");
        wr(num(0, 17), 32'h25);
        reqs(1, 0, 0, 0, "R6"); judge();
        @(negedge clk);
        reqs(0, 0, 0, 0, "R6"); judge();
        wr(num(0, 17), 32'h25);
        reqs(0, 0, 0, 0, "R6"); judge();
        wr(num(0, 17), 32'h24);
        reqs(1, 0, 0, 0, "R6"); judge();
        wr(num(0, 17), 32'h64);
        reqs(1, 0, 0, 0, "R6"); judge();

        // R7: power management halt
        cur_pc_i = 32'h1000;
        wr(num(8, 0), 32'h10);
        reqs(0, 0, 0, 1, "R7"); push(7, 32'h1004, "R7"); judge();
        wr(num(8, 0), 32'h01);
        reqs(0, 0, 0, 0, "R7"); judge();
        cur_pc_i = 32'h2220;
        wr(num(8, 0), 32'h20);
        reqs(0, 0, 0, 1, "R7"); push(7, 32'h2224, "R7"); judge();
        rd(num(8, 0), 0, 32'h20, "R7");

        // R8: next-PC redirect
        cur_pc_i = 32'h2000;
        wr(num(0, 16), 32'h2000);
        reqs(0, 0, 0, 0, "R8"); judge();
        wr(num(0, 16), 32'h3000);
        reqs(0, 0, 1, 0, "R8"); push(5, 32'h3000, "R8"); judge();
        rd(num(0, 16), 32'h0, 32'h2000, "R8");

        // R9: shadow registers
        wr(num(0, 1024 + 37), 32'hABCD);
        rd(num(0, 1024 + 37), 0, 32'hABCD, "R9");
        rd(num(0, 1024 + 5), 32'h9, 32'h0, "R9");
        rd(num(0, 1024 + 64), 32'h7777, 32'h7777, "R9");

        // R10: way-0 match words and page flush
        wr(num(1, 512 + 3), 32'h0004_6001);
        reqs(0, 0, 0, 0, "R10"); judge();
        wr(num(1, 512 + 3), 32'h0);
        reqs(0, 1, 0, 0, "R10"); push(3, 32'h0004_6000, "R10"); judge();
        rd(num(1, 512 + 3), 32'h1, 32'h0, "R10");
        wr(num(1, 768), 32'h1234);
        reqs(0, 0, 0, 0, "R10"); judge();
        rd(num(1, 768), 32'h4321, 32'h4321, "R10");
        rd(num(1, 512 + 8), 32'h8888, 32'h8888, "R10");

        // R11: constants
        wr(num(0, 0), 32'h0);
        rd(num(0, 0), 0, 32'h1200_0001, "R11");
        rd(num(0, 128), 0, 32'd3, "R11");
        rd(num(0, 129), 0, 32'd4, "R11");

        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule